// File: doc/BRIEF.md
# Mailbox Command Requester Sequencer

This block runs one command across a register-mapped mailbox for a local user. The user hands over a message identifier and a 32-bit argument on a valid/ready request. The sequencer then drives a simple single-outstanding register master port through the whole exchange. First it waits for the mailbox to report a non-busy status. Next it clears the status register, stores the argument and writes the identifier, which triggers the far side. It then polls the status register until the far side answers or the retry budget runs out.

Polling between reads is paced by a fixed interval. The interval is the product of a poll period in microseconds and a cycles-per-microsecond constant, both parameters. The number of retries is a runtime input. The outcome comes back as a one-cycle response pulse with three flags: success, failure and timeout. The pulse also carries the identifier and argument of the command. On success, the data returned is the value read back from the argument register; the status code itself is not returned. On a failure code, the sequencer restores the success code in the status register before it reports.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_req` is 0 and `rsp_valid` is 0.
- R2: A request is taken only while `req_ready` is 1, and `req_ready` is 1 only when no command is in progress. While a command runs, `req_ready` is 0, no bus access is requested while idle, and `req_valid` pulses during a command change nothing.
- R3: Before issuing, the block reads the status register (address `STS_ADDR`) until it reads non-zero. Any non-zero value, including 0xFF, lets it proceed.
- R4: If the pre-issue reads return 0 for `retry_limit`+1 reads in a row, the block ends with `rsp_timeout`=1 and `rsp_data`=0. It makes no write.
- R5: Issue is exactly three writes in this order: 0 to `STS_ADDR`, the argument to `ARG_ADDR`, then the identifier (zero-extended) to `CMD_ADDR`.
- R6: Each poll phase makes at most `retry_limit`+1 reads of `STS_ADDR`. After a read that returns 0 and still has budget left, the block waits POLL_US*CYC_PER_US cycles in the wait state before it requests the next read.
- R7: If the post-issue status read returns 0xFF, the block writes 1 to `STS_ADDR`. It then ends with `rsp_fail`=1 and `rsp_data`=0.
- R8: If the post-issue status read returns any other non-zero value, the block reads `ARG_ADDR`. It then ends with `rsp_ok`=1 and `rsp_data` equal to that read value.
- R9: If the post-issue reads return 0 for `retry_limit`+1 reads, the block ends with `rsp_timeout`=1 and `rsp_data`=0. It makes no further access.
- R10: The bus has one access in flight at a time. `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay stable until the cycle in which `bus_ack` is 1.
- R11: `rsp_valid` lasts one cycle, and exactly one of `rsp_ok`, `rsp_fail` and `rsp_timeout` is 1 with it. `rsp_id` and `rsp_arg` echo the command's identifier and argument.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_id | input | ID_W | Message identifier |
| req_arg | input | DATA_W | Command argument |
| retry_limit | input | RETRY_W | Extra status reads allowed per poll phase |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_ok | output | 1 | Completed with a non-failure status |
| rsp_fail | output | 1 | Far side returned the failure code |
| rsp_timeout | output | 1 | A poll phase ran out of retries |
| rsp_data | output | DATA_W | Argument register read-back on success, else 0 |
| rsp_id | output | ID_W | Identifier of the completed command |
| rsp_arg | output | DATA_W | Argument of the completed command |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Access complete this cycle |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |

## Verification
The bench drives a register slave with a scripted status sequence. It predicts every access in order and checks the exact cycle spacing between back-to-back status reads, with slave latencies of zero and two cycles. The corner cases are these:
- A zero retry budget: a design that miscounts makes two reads or none.
- A pre-issue 0xFF, which must be treated as non-busy: a design that tests for the failure code too early would skip the issue.
- A timeout in each phase: a design that gets this wrong would write after an early abort, or would read the argument register after a late one.
- The failure path: a design that gets this wrong would skip the write-back of 1, or would return the argument instead of zero.

Request pulses during a busy command would show up as shifted or extra accesses if the design took them.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_RD,
    ST_PRE_WAIT,
    ST_CLR_WR,
    ST_ARG_WR,
    ST_CMD_WR,
    ST_POST_RD,
    ST_POST_WAIT,
    ST_RECOV_WR,
    ST_DATA_RD
  } seq_state_e;

  localparam int unsigned CODE_BUSY = 32'h0000_0000;
  localparam int unsigned CODE_OK   = 32'h0000_0001;
  localparam int unsigned CODE_FAIL = 32'h0000_00FF;

  function automatic int unsigned poll_cycles(input int unsigned us,
                                              input int unsigned cyc_per_us);
    return us * cyc_per_us;
  endfunction

  function automatic logic is_busy(input logic [31:0] v);
    return v == CODE_BUSY;
  endfunction

  function automatic logic is_fail(input logic [31:0] v);
    return v == CODE_FAIL;
  endfunction

endpackage

// File: rtl/mbox_interval_timer.sv
module mbox_interval_timer #(
  parameter int unsigned INTERVAL = 1000,
  localparam int unsigned TW = (INTERVAL < 2) ? 1 : $clog2(INTERVAL)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start)
      cnt_q <= TW'(INTERVAL - 1);
    else if (run && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/mbox_retry_budget.sv
module mbox_retry_budget #(
  parameter int unsigned RETRY_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               use_one,
  input  logic [RETRY_W-1:0] limit,
  output logic               spent
);
  logic [RETRY_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      left_q <= '0;
    else if (load)
      left_q <= limit;
    else if (use_one && left_q != '0)
      left_q <= left_q - 1'b1;
  end

  assign spent = (left_q == '0);
endmodule

// File: rtl/mbox_access_gen.sv
module mbox_access_gen
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ID_W     = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] ARG_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h18
) (
  input  seq_state_e        state,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [DATA_W-1:0] cmd_arg,
  output logic              acc_req,
  output logic              acc_we,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata
);
  always_comb begin
    acc_req   = 1'b1;
    acc_we    = 1'b0;
    acc_addr  = STS_ADDR;
    acc_wdata = '0;
    unique case (state)
      ST_PRE_RD, ST_POST_RD: begin
        acc_addr = STS_ADDR;
      end
      ST_CLR_WR: begin
        acc_we    = 1'b1;
        acc_wdata = DATA_W'(CODE_BUSY);
      end
      ST_ARG_WR: begin
        acc_we    = 1'b1;
        acc_addr  = ARG_ADDR;
        acc_wdata = cmd_arg;
      end
      ST_CMD_WR: begin
        acc_we    = 1'b1;
        acc_addr  = CMD_ADDR;
        acc_wdata = {{(DATA_W-ID_W){1'b0}}, cmd_id};
      end
      ST_RECOV_WR: begin
        acc_we    = 1'b1;
        acc_wdata = DATA_W'(CODE_OK);
      end
      ST_DATA_RD: begin
        acc_addr = ARG_ADDR;
      end
      default: begin
        acc_req = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned ID_W       = 8,
  parameter int unsigned RETRY_W    = 18,
  parameter int unsigned POLL_US    = 10,
  parameter int unsigned CYC_PER_US = 100,
  parameter logic [ADDR_W-1:0] STS_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] ARG_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ID_W-1:0]    req_id,
  input  logic [DATA_W-1:0]  req_arg,
  input  logic [RETRY_W-1:0] retry_limit,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic               rsp_fail,
  output logic               rsp_timeout,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [ID_W-1:0]    rsp_id,
  output logic [DATA_W-1:0]  rsp_arg,
  output logic               bus_req,
  output logic               bus_we,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_ack,
  input  logic [DATA_W-1:0]  bus_rdata
);
  localparam int unsigned INTERVAL = poll_cycles(POLL_US, CYC_PER_US);

  seq_state_e        state_q, state_d;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] arg_q;

  // named internal events
  logic acc_done, rd_busy, rd_fail, take_req;
  logic budget_load, budget_use, budget_spent;
  logic tmr_start, tmr_run, tmr_expired;
  logic fin_ok, fin_fail, fin_to;

  assign take_req = req_valid && (state_q == ST_IDLE);
  assign acc_done = bus_req && bus_ack;
  assign rd_busy  = acc_done && !bus_we && is_busy(32'(bus_rdata));
  assign rd_fail  = acc_done && !bus_we && is_fail(32'(bus_rdata));

  mbox_access_gen #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W),
    .STS_ADDR(STS_ADDR), .ARG_ADDR(ARG_ADDR), .CMD_ADDR(CMD_ADDR)
  ) u_acc (
    .state    (state_q),
    .cmd_id   (id_q),
    .cmd_arg  (arg_q),
    .acc_req  (bus_req),
    .acc_we   (bus_we),
    .acc_addr (bus_addr),
    .acc_wdata(bus_wdata)
  );

  mbox_retry_budget #(.RETRY_W(RETRY_W)) u_budget (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (budget_load),
    .use_one(budget_use),
    .limit  (retry_limit),
    .spent  (budget_spent)
  );

  mbox_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .run    (tmr_run),
    .expired(tmr_expired)
  );

  assign tmr_run = (state_q == ST_PRE_WAIT) || (state_q == ST_POST_WAIT);

  always_comb begin
    state_d     = state_q;
    budget_load = 1'b0;
    budget_use  = 1'b0;
    tmr_start   = 1'b0;
    fin_ok      = 1'b0;
    fin_fail    = 1'b0;
    fin_to      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (take_req) begin
          state_d     = ST_PRE_RD;
          budget_load = 1'b1;
        end
      end
      ST_PRE_RD, ST_POST_RD: begin
        if (acc_done) begin
          if (!rd_busy) begin
            if (state_q == ST_PRE_RD) state_d = ST_CLR_WR;
            else if (rd_fail)         state_d = ST_RECOV_WR;
            else                      state_d = ST_DATA_RD;
          end else if (budget_spent) begin
            state_d = ST_IDLE;
            fin_to  = 1'b1;
          end else begin
            state_d    = (state_q == ST_PRE_RD) ? ST_PRE_WAIT : ST_POST_WAIT;
            budget_use = 1'b1;
            tmr_start  = 1'b1;
          end
        end
      end
      ST_PRE_WAIT:  if (tmr_expired) state_d = ST_PRE_RD;
      ST_POST_WAIT: if (tmr_expired) state_d = ST_POST_RD;
      ST_CLR_WR:    if (acc_done) state_d = ST_ARG_WR;
      ST_ARG_WR:    if (acc_done) state_d = ST_CMD_WR;
      ST_CMD_WR: begin
        if (acc_done) begin
          state_d     = ST_POST_RD;
          budget_load = 1'b1;
        end
      end
      ST_RECOV_WR: begin
        if (acc_done) begin
          state_d  = ST_IDLE;
          fin_fail = 1'b1;
        end
      end
      ST_DATA_RD: begin
        if (acc_done) begin
          state_d = ST_IDLE;
          fin_ok  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      id_q        <= '0;
      arg_q       <= '0;
      rsp_valid   <= 1'b0;
      rsp_ok      <= 1'b0;
      rsp_fail    <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_data    <= '0;
      rsp_id      <= '0;
      rsp_arg     <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid   <= fin_ok || fin_fail || fin_to;
      rsp_ok      <= fin_ok;
      rsp_fail    <= fin_fail;
      rsp_timeout <= fin_to;
      rsp_data    <= fin_ok ? bus_rdata : '0;
      if (take_req) begin
        id_q  <= req_id;
        arg_q <= req_arg;
      end
      if (fin_ok || fin_fail || fin_to) begin
        rsp_id  <= id_q;
        rsp_arg <= arg_q;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
endmodule

// File: rtl/mbox_cmd_seq_chk.sv
module mbox_cmd_seq_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] ARG_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic              rsp_fail,
  input logic              rsp_timeout,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_rdata
);
  logic [ADDR_W-1:0] last_wr_addr;
  logic [DATA_W-1:0] last_wr_data;
  logic [DATA_W-1:0] last_rd_val;
  logic [ADDR_W-1:0] last_addr;
  logic              last_we;
  logic              done;

  assign done = bus_req && bus_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_wr_addr <= STS_ADDR;
      last_wr_data <= '1;
      last_rd_val  <= '1;
      last_addr    <= '0;
      last_we      <= 1'b0;
    end else if (done) begin
      last_addr <= bus_addr;
      last_we   <= bus_we;
      if (bus_we) begin
        last_wr_addr <= bus_addr;
        last_wr_data <= bus_wdata;
      end else begin
        last_rd_val <= bus_rdata;
      end
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req);

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_one_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_ok, rsp_fail, rsp_timeout}) == 1);

  assert_arg_after_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && bus_we && bus_addr == ARG_ADDR |-> last_wr_addr == STS_ADDR && last_wr_data == '0);

  assert_cmd_after_arg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && bus_we && bus_addr == CMD_ADDR |-> last_wr_addr == ARG_ADDR);

  assert_recover_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && bus_we && bus_addr == STS_ADDR && bus_wdata == DATA_W'(1)
      |-> last_rd_val == DATA_W'(8'hFF));

  assert_fail_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fail |-> last_we && last_addr == STS_ADDR && last_wr_data == DATA_W'(1));

  assert_ok_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ok |-> !last_we && last_addr == ARG_ADDR);

  assert_timeout_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_timeout |-> !last_we && last_addr == STS_ADDR && last_rd_val == '0);
endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .STS_ADDR(STS_ADDR), .ARG_ADDR(ARG_ADDR), .CMD_ADDR(CMD_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ok     (rsp_ok),
  .rsp_fail   (rsp_fail),
  .rsp_timeout(rsp_timeout),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_ack    (bus_ack),
  .bus_rdata  (bus_rdata)
);

// File: tb/mbox_cmd_seq_bench.sv
module mbox_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int IW = 8;
  localparam int RW = 18;
  localparam int P_US = 2;
  localparam int C_US = 2;
  localparam int WAIT_CYC = P_US * C_US;
  localparam logic [AW-1:0] A_STS = 8'h10;
  localparam logic [AW-1:0] A_ARG = 8'h14;
  localparam logic [AW-1:0] A_CMD = 8'h18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [IW-1:0] req_id = '0;
  logic [DW-1:0] req_arg = '0;
  logic [RW-1:0] retry_limit = '0;
  logic rsp_valid, rsp_ok, rsp_fail, rsp_timeout;
  logic [DW-1:0] rsp_data, rsp_arg;
  logic [IW-1:0] rsp_id;
  logic bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_cmd_seq #(
    .DATA_W(DW), .ADDR_W(AW), .ID_W(IW), .RETRY_W(RW),
    .POLL_US(P_US), .CYC_PER_US(C_US),
    .STS_ADDR(A_STS), .ARG_ADDR(A_ARG), .CMD_ADDR(A_CMD)
  ) u_mbox_cmd_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_arg(req_arg),
    .retry_limit(retry_limit),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fail(rsp_fail), .rsp_timeout(rsp_timeout),
    .rsp_data(rsp_data), .rsp_id(rsp_id), .rsp_arg(rsp_arg),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int n_tests = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // slave model and expected access stream
  int unsigned script[$];
  logic [DW-1:0] fw_reply = '0;
  logic [DW-1:0] reg_sts = 32'h1, reg_arg = '0, reg_cmd = '0;
  logic exp_we[$];
  logic [AW-1:0] exp_addr[$];
  logic [DW-1:0] exp_wd[$];
  int lat = 0;
  int lat_cnt = 0;
  int cyc = 0;
  int last_sts_rd = 0;
  bit prev_sts_rd = 0;

  task automatic slave_access();
    if (bus_we) begin
      if (bus_addr == A_STS) reg_sts = bus_wdata;
      if (bus_addr == A_ARG) reg_arg = bus_wdata;
      if (bus_addr == A_CMD) begin reg_cmd = bus_wdata; reg_arg = fw_reply; end
    end else begin
      if (bus_addr == A_STS) bus_rdata = (script.size() > 0) ? script.pop_front() : 32'h0;
      else if (bus_addr == A_ARG) bus_rdata = reg_arg;
      else bus_rdata = reg_cmd;
    end
    // R10 / R5 / R3: compare against predicted access stream
    if (exp_we.size() == 0) begin
      chk(0, "R2 unexpected access", {24'h0, bus_addr}, 32'h0);
    end else begin
      logic ew; logic [AW-1:0] ea; logic [DW-1:0] ed;
      ew = exp_we.pop_front(); ea = exp_addr.pop_front(); ed = exp_wd.pop_front();
      chk(bus_we == ew && bus_addr == ea && (!ew || bus_wdata == ed),
          "R5 access mismatch", {bus_we, 15'h0, 8'h0, bus_addr}, {ew, 15'h0, 8'h0, ea});
      if (ew) chk(bus_wdata == ed, "R5 write data", bus_wdata, ed);
    end
    if (!bus_we && bus_addr == A_STS) begin
      if (prev_sts_rd)
        chk(cyc - last_sts_rd == WAIT_CYC + 1 + lat, "R6 poll spacing",
            32'(cyc - last_sts_rd), 32'(WAIT_CYC + 1 + lat));
      prev_sts_rd = 1;
      last_sts_rd = cyc;
    end else begin
      prev_sts_rd = 0;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      bus_ack = 0; lat_cnt = 0;
    end else if (bus_ack) begin
      bus_ack = 0; lat_cnt = 0;
    end else if (bus_req) begin
      if (lat_cnt == lat) begin
        bus_ack = 1;
        slave_access();
      end else begin
        lat_cnt++;
      end
    end
  end

  // expected outcome: 0 ok, 1 fail, 2 timeout
  int exp_kind;
  logic [DW-1:0] exp_data;

  task automatic push_exp(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_we.push_back(we); exp_addr.push_back(a); exp_wd.push_back(d);
  endtask

  task automatic plan(input logic [IW-1:0] id, input logic [DW-1:0] arg, input int limit);
    int idx = 0;
    int unsigned v = 0;
    for (int k = 0; k <= limit; k++) begin
      push_exp(0, A_STS, 0);
      v = (idx < script.size()) ? script[idx] : 0;
      idx++;
      if (v != 0) break;
      if (k == limit) begin exp_kind = 2; exp_data = 0; return; end
    end
    push_exp(1, A_STS, 0);
    push_exp(1, A_ARG, arg);
    push_exp(1, A_CMD, {24'h0, id});
    for (int k = 0; k <= limit; k++) begin
      push_exp(0, A_STS, 0);
      v = (idx < script.size()) ? script[idx] : 0;
      idx++;
      if (v != 0) break;
      if (k == limit) begin exp_kind = 2; exp_data = 0; return; end
    end
    if (v == 32'hFF) begin
      push_exp(1, A_STS, 32'h1); exp_kind = 1; exp_data = 0;
    end else begin
      push_exp(0, A_ARG, 0); exp_kind = 0; exp_data = fw_reply;
    end
  endtask

  task automatic run_cmd(input string tag, input logic [IW-1:0] id, input logic [DW-1:0] arg,
                         input int limit, input int latency, input bit poke);
    int waited = 0;
    lat = latency;
    prev_sts_rd = 0;
    plan(id, arg, limit);
    @(negedge clk);
    retry_limit = RW'(limit);
    req_id = id; req_arg = arg; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      @(negedge clk);
      chk(req_ready == 0, "R2 ready low while busy", {31'h0, req_ready}, 0);
      req_id = ~id; req_arg = ~arg; req_valid = 1;
      @(negedge clk); @(negedge clk);
      req_valid = 0;
    end
    while (!rsp_valid && waited < 5000) begin @(negedge clk); waited++; end
    chk(rsp_valid, {tag, " response arrived"}, {31'h0, rsp_valid}, 1);
    chk(rsp_ok == (exp_kind == 0), {tag, " R8 ok flag"}, {31'h0, rsp_ok}, {31'h0, exp_kind == 0});
    chk(rsp_fail == (exp_kind == 1), {tag, " R7 fail flag"}, {31'h0, rsp_fail}, {31'h0, exp_kind == 1});
    chk(rsp_timeout == (exp_kind == 2), {tag, " R4/R9 timeout flag"}, {31'h0, rsp_timeout}, {31'h0, exp_kind == 2});
    chk(rsp_data == exp_data, {tag, " R8 data"}, rsp_data, exp_data);
    chk(rsp_id == id && rsp_arg == arg, {tag, " R11 echo"}, rsp_arg, arg);
    @(negedge clk);
    chk(!rsp_valid, {tag, " R11 single pulse"}, {31'h0, rsp_valid}, 0);
    chk(req_ready, {tag, " R2 ready after done"}, {31'h0, req_ready}, 1);
    repeat (6) @(negedge clk);
    chk(exp_we.size() == 0, {tag, " R9 all accesses seen"}, 32'(exp_we.size()), 0);
    exp_we.delete(); exp_addr.delete(); exp_wd.delete();
    script.delete();
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R1 ready at reset", {31'h0, req_ready}, 1);
    chk(bus_req == 0, "R1 no bus at reset", {31'h0, bus_req}, 0);
    chk(rsp_valid == 0, "R1 no rsp at reset", {31'h0, rsp_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R8 immediate success
    script = '{1, 1}; fw_reply = 32'hCAFE_0001;
    run_cmd("ok_fast", 8'h04, 32'h0000_0258, 3, 0, 0);
    // R3 R6 busy polling both phases, slow slave, request pokes (R2)
    script = '{0, 0, 1, 0, 0, 0, 5}; fw_reply = 32'h1234_5678;
    run_cmd("busy_poll", 8'h06, 32'h0000_0190, 4, 2, 1);
    // R7 failure code
    script = '{1, 0, 32'hFF}; fw_reply = 32'hDEAD_BEEF;
    run_cmd("fail", 8'h11, 32'h0000_0004, 3, 1, 0);
    // R4 pre-issue timeout
    script = '{0, 0, 0};
    run_cmd("pre_to", 8'h0B, 32'h0000_00AA, 2, 0, 0);
    // R9 post-issue timeout
    script = '{1, 0, 0}; fw_reply = 32'h5555_5555;
    run_cmd("post_to", 8'h15, 32'h0000_0001, 1, 2, 0);
    // R4 zero budget: a single read
    script = '{0};
    run_cmd("zero_budget", 8'h02, 32'h0, 0, 0, 0);
    // R3 pre-issue 0xFF counts as non-busy, post 0xFE is success
    script = '{32'hFF, 32'hFE}; fw_reply = 32'h0000_0777;
    run_cmd("ff_pre", 8'h17, 32'h0000_0001, 2, 1, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule